// File: doc/BRIEF.md
# Masked-write GPIO data bank

This block is one 32-pin general-purpose I/O bank behind a simple register bus. It holds the output data word, a direction word and an output-enable word. It also presents the synchronized levels of all 32 pins as a read-only word. Each bus access is one cycle, with address, write strobe, write data and read data; reads are combinational from registered state.

Output bits can be changed without a read-modify-write. Two write-only ports each cover half of the bank. The upper 16 bits of a write to one of them are a per-bit mask, and the lower 16 bits are the new values. Only the bits whose mask bit is clear change, so any subset of pins in one half can be set or cleared in a single atomic access.

The output word can also be read and written whole at its own address. A pin drives its pad only when it is both configured as an output and enabled. The bank index parameter places every register in the address map.

Top module: `gpio_mw_bank`

## Requirements
- R1: After synchronous reset the output word, direction word and output-enable word read 0, and `pin_out` and `pin_oe` are all 0.
- R2: A write to the low masked port (address 8×BANK_IDX) sets output bit i (0..15) to wdata[i] where wdata[16+i] is 0, and leaves it unchanged where wdata[16+i] is 1; bits 31:16 of the output word are untouched.
- R3: A write to the high masked port (address 8×BANK_IDX+4) applies the same rule to output bits 16..31, with wdata[i] and wdata[16+i] governing pin 16+i; bits 15:0 are untouched.
- R4: Reads of either masked port return 0.
- R5: The pin-level word (address 0x060+4×BANK_IDX) returns bit n = `pin_in[n]` as sampled two clock edges earlier; writes to it change no state.
- R6: The direction word (address 0x204+0x40×BANK_IDX) reads back what was last written; 1 marks a pin as an output.
- R7: The output-enable word (address 0x208+0x40×BANK_IDX) reads back what was last written, and `pin_oe[n]` equals direction bit n AND enable bit n.
- R8: The full output word (address 0x3C0+4×BANK_IDX) is written whole, reads back the current output word, and `pin_out` always equals it.
- R9: Addresses that belong to no register of this bank, including those of other bank indices, read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output data to pads |
| pin_oe | output | 32 | Per-pin pad drive enable |

## Verification
The bench builds the bank with BANK_IDX = 2, so that every register sits at a nonzero, bank-scaled offset. The addresses that bank 0 would use then fall outside the map and must read 0 and ignore writes. A decode that dropped the bank term or scaled it wrongly would therefore show up at once. The two-stage synchronizer depth is left at its default, so the pin-level word lags the pins by two edges.

// File: rtl/gpio_mw_bank_pkg.sv
package gpio_mw_bank_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int ADDR_W = 12;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        logic mlo;
        logic mhi;
        logic lvl;
        logic dir;
        logic oen;
        logic word;
    } reg_sel_t;

    function automatic addr_t adr_mlo(input int b);
        return addr_t'(8 * b);
    endfunction

    function automatic addr_t adr_mhi(input int b);
        return addr_t'(4 + 8 * b);
    endfunction

    function automatic addr_t adr_lvl(input int b);
        return addr_t'(12'h060 + 4 * b);
    endfunction

    function automatic addr_t adr_dir(input int b);
        return addr_t'(12'h204 + 12'h040 * b);
    endfunction

    function automatic addr_t adr_oen(input int b);
        return addr_t'(12'h208 + 12'h040 * b);
    endfunction

    function automatic addr_t adr_word(input int b);
        return addr_t'(12'h3C0 + 4 * b);
    endfunction

    // Keep bits whose mask bit is 1, take new data where it is 0.
    function automatic half_t masked_merge(input half_t old_v, input half_t mask, input half_t data);
        return (old_v & mask) | (data & ~mask);
    endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
    import gpio_mw_bank_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  addr_t    addr,
    output reg_sel_t sel
);
    localparam addr_t A_MLO  = adr_mlo(BANK_IDX);
    localparam addr_t A_MHI  = adr_mhi(BANK_IDX);
    localparam addr_t A_LVL  = adr_lvl(BANK_IDX);
    localparam addr_t A_DIR  = adr_dir(BANK_IDX);
    localparam addr_t A_OEN  = adr_oen(BANK_IDX);
    localparam addr_t A_WORD = adr_word(BANK_IDX);

    always_comb begin
        sel      = '0;
        sel.mlo  = (addr == A_MLO);
        sel.mhi  = (addr == A_MHI);
        sel.lvl  = (addr == A_LVL);
        sel.dir  = (addr == A_DIR);
        sel.oen  = (addr == A_OEN);
        sel.word = (addr == A_WORD);
    end
endmodule

// File: rtl/gpio_mw_cfgreg.sv
module gpio_mw_cfgreg
    import gpio_mw_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/gpio_mw_outreg.sv
module gpio_mw_outreg
    import gpio_mw_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  reg_sel_t sel,
    input  word_t    wdata,
    output word_t    q
);
    localparam int NHALF = WORD_W / HALF_W;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        half_t r;
        logic  hit_mask;
        assign hit_mask = we && ((h == 0) ? sel.mlo : sel.mhi);

        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (we && sel.word)
                r <= wdata[h*HALF_W +: HALF_W];
            else if (hit_mask)
                r <= masked_merge(r, wdata[WORD_W-1:HALF_W], wdata[HALF_W-1:0]);
        end

        assign q[h*HALF_W +: HALF_W] = r;
    end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync
    import gpio_mw_bank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t d,
    output word_t q
);
    word_t st [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        always_ff @(posedge clk) begin
            if (rst)         st[s] <= '0;
            else if (s == 0) st[s] <= d;
            else             st[s] <= st[(s == 0) ? 0 : s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
    import gpio_mw_bank_pkg::*;
#(
    parameter int BANK_IDX    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] reg_addr,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] pin_in,
    output logic [31:0] pin_out,
    output logic [31:0] pin_oe
);
    reg_sel_t sel;
    word_t    dir_q, oen_q, out_q, lvl_q;

    gpio_mw_decode #(.BANK_IDX(BANK_IDX)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    gpio_mw_cfgreg u_dir (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_we && sel.dir),
        .wdata (reg_wdata),
        .q     (dir_q)
    );

    gpio_mw_cfgreg u_oen (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_we && sel.oen),
        .wdata (reg_wdata),
        .q     (oen_q)
    );

    gpio_mw_outreg u_out (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (sel),
        .wdata (reg_wdata),
        .q     (out_q)
    );

    gpio_mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel.lvl)  reg_rdata = lvl_q;
        if (sel.dir)  reg_rdata = dir_q;
        if (sel.oen)  reg_rdata = oen_q;
        if (sel.word) reg_rdata = out_q;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q & oen_q;
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk
    import gpio_mw_bank_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input logic        clk,
    input logic        rst,
    input logic [11:0] reg_addr,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [31:0] pin_out,
    input logic [31:0] pin_oe
);
    localparam addr_t C_MLO  = adr_mlo(BANK_IDX);
    localparam addr_t C_MHI  = adr_mhi(BANK_IDX);
    localparam addr_t C_DIR  = adr_dir(BANK_IDX);
    localparam addr_t C_OEN  = adr_oen(BANK_IDX);
    localparam addr_t C_WORD = adr_word(BANK_IDX);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == 32'h0 && pin_oe == 32'h0));

    // R2
    full_mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == C_MLO && reg_wdata[31:16] == 16'hFFFF) |=> $stable(pin_out));

    // R3
    high_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == C_MHI) |=> $stable(pin_out[15:0]));

    // R4
    masked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == C_MLO || reg_addr == C_MHI) |-> reg_rdata == 32'h0);

    // R7
    oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && (reg_addr == C_DIR || reg_addr == C_OEN)) |=> $stable(pin_oe));

    // R8
    word_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == C_WORD) |-> reg_rdata == pin_out);
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.BANK_IDX(BANK_IDX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_mw_bank_tb_top.sv
module gpio_mw_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BANK = 2;

    localparam logic [11:0] T_MLO  = 12'h010;
    localparam logic [11:0] T_MHI  = 12'h014;
    localparam logic [11:0] T_LVL  = 12'h068;
    localparam logic [11:0] T_DIR  = 12'h284;
    localparam logic [11:0] T_OEN  = 12'h288;
    localparam logic [11:0] T_WORD = 12'h3C8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int vectors = 0;
    int miscompares = 0;

    logic [31:0] m_out = '0, m_dir = '0, m_oen = '0;
    logic [31:0] lvl_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mw_bank #(.BANK_IDX(BANK)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            T_LVL:   return lvl_q[0];
            T_DIR:   return m_dir;
            T_OEN:   return m_oen;
            T_WORD:  return m_out;
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [11:0] a, input logic we, input logic [31:0] wd,
                        input logic [31:0] pins, input string tag);
        @(negedge clk);
        reg_addr = a; reg_we = we; reg_wdata = wd; pin_in = pins;
        #1;
        vectors++;
        cmp(tag, "rdata", reg_rdata, model_read(a));
        cmp(tag, "pin_out", pin_out, m_out);
        cmp(tag, "pin_oe", pin_oe, m_dir & m_oen);
        @(posedge clk);
        if (we) begin
            case (a)
                T_MLO: for (int i = 0; i < 16; i++) if (!wd[16+i]) m_out[i] = wd[i];
                T_MHI: for (int i = 0; i < 16; i++) if (!wd[16+i]) m_out[16+i] = wd[i];
                T_DIR:  m_dir = wd;
                T_OEN:  m_oen = wd;
                T_WORD: m_out = wd;
                default: ;
            endcase
        end
        void'(lvl_q.pop_front());
        lvl_q.push_back(pins);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        lvl_q.push_back(32'h0);
        lvl_q.push_back(32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step(T_DIR, 0, 0, 0, "R1");
        step(T_OEN, 0, 0, 0, "R1");
        step(T_WORD, 0, 0, 0, "R1");
        // R6 direction
        step(T_DIR, 1, 32'hA5A5_0F0F, 0, "R6");
        step(T_DIR, 0, 0, 0, "R6");
        // R7 enable and pad drive
        step(T_OEN, 1, 32'hFFFF_0000, 0, "R7");
        step(T_OEN, 0, 0, 0, "R7");
        step(T_OEN, 1, 32'h0F0F_FFFF, 0, "R7");
        step(T_DIR, 0, 0, 0, "R7");
        // R8 full word
        step(T_WORD, 1, 32'h1234_5678, 0, "R8");
        step(T_WORD, 0, 0, 0, "R8");
        // R2 low masked
        step(T_MLO, 1, 32'h00FF_ABCD, 0, "R2");
        step(T_WORD, 0, 0, 0, "R2");
        step(T_MLO, 1, 32'hFFFF_0000, 0, "R2");
        step(T_MLO, 1, 32'h0000_0000, 0, "R2");
        step(T_WORD, 0, 0, 0, "R2");
        // R3 high masked
        step(T_MHI, 1, 32'hF0F0_5A5A, 0, "R3");
        step(T_WORD, 0, 0, 0, "R3");
        step(T_MHI, 1, 32'h7FFF_FFFF, 0, "R3");
        step(T_WORD, 0, 0, 0, "R3");
        // R4 masked ports read 0
        step(T_MLO, 0, 0, 0, "R4");
        step(T_MHI, 0, 0, 0, "R4");
        // R5 pin levels, two-edge lag, writes ignored
        step(T_LVL, 0, 0, 32'hDEAD_BEEF, "R5");
        step(T_LVL, 0, 0, 32'h0000_FFFF, "R5");
        step(T_LVL, 1, 32'h5555_5555, 32'h8000_0001, "R5");
        step(T_LVL, 0, 0, 32'h8000_0001, "R5");
        step(T_LVL, 0, 0, 32'h8000_0001, "R5");
        step(T_WORD, 0, 0, 32'h8000_0001, "R5");
        // R9 other-bank and unmapped addresses
        step(12'h000, 1, 32'h0000_FFFF, 0, "R9");
        step(12'h004, 1, 32'h0000_FFFF, 0, "R9");
        step(12'h204, 1, 32'hFFFF_FFFF, 0, "R9");
        step(12'h208, 1, 32'hFFFF_FFFF, 0, "R9");
        step(12'h3C0, 1, 32'hFFFF_FFFF, 0, "R9");
        step(12'h204, 0, 0, 0, "R9");
        step(12'h060, 0, 0, 0, "R9");
        step(12'hFFC, 0, 0, 0, "R9");
        step(T_WORD, 0, 0, 0, "R9");
        // mixed traffic over all registers
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 400; k++) begin
            logic [11:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = T_MLO;
                3'd2, 3'd3: a = T_MHI;
                3'd4:       a = T_DIR;
                3'd5:       a = T_OEN;
                3'd6:       a = T_WORD;
                default:    a = T_LVL;
            endcase
            step(a, lfsr[3], {lfsr[15:0], lfsr[31:16]} ^ 32'h3C3C_A5A5, lfsr ^ {lfsr[7:0], 24'h0}, "R2");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule